// File: doc/BRIEF.md
# USB Endpoint Event Interrupt Aggregator

This block gathers the event flags of the five endpoints of a USB device controller and turns them into interrupt requests. For each endpoint it holds eight sticky flags: transmit-ready, received OUT, received SETUP, stalled, NAK sent to IN, NAK sent to OUT/PING, isochronous overflow and isochronous underflow. A one-cycle hardware pulse sets a flag. Firmware can only clear flags. Each flag passes through an enable bit into a per-endpoint summary line. Overflow and underflow share a single flow-error enable. The global request is the OR of the five summary lines.

Firmware reaches the block through a simple register port with a write strobe, an address, write data and combinational read data. An endpoint-select register steers the flag, enable and configuration addresses to one endpoint. Each endpoint's configuration holds its direction and its transfer type. The direction decides which flags may set: an IN endpoint never holds received-SETUP, and an OUT endpoint never holds transmit-ready. The ports are all plain control and status signals. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `usb_ep_irq_hub`

## Requirements
- R1: Flag register (address 1) bit positions: 0 transmit-ready, 1 received-OUT, 2 received-SETUP, 3 stalled, 4 NAK-in, 5 NAK-out, 6 overflow, 7 underflow. A pulse on an endpoint's event bit sets the flag at the next clock edge. A firmware write of 0 to a flag bit clears it. A firmware write of 1 leaves it unchanged and never sets it.
- R2: When a hardware set and a firmware clear reach the same flag in one cycle, the flag ends up set.
- R3: While an endpoint is configured IN, its received-SETUP flag (bit 2) reads 0 from the cycle after the IN setting onward, and a SETUP pulse cannot set it.
- R4: While an endpoint is configured OUT, its transmit-ready flag (bit 0) is held at 0.
- R5: Enable register (address 2) bits 0..5 each gate the flag at the same bit position into the endpoint's summary line, `ep_irq[n]`. A set flag whose enable is 0 raises no request.
- R6: Enable bit 6 is the flow-error enable. It gates both overflow (flag bit 6) and underflow (flag bit 7). Enable bits 0..5 do not gate these two flags.
- R7: `ep_irq[n]` is high exactly while some enabled flag of endpoint n is set, and it drops once firmware has cleared those flags. `irq` is the OR of all `ep_irq` bits. Address 4 reads `ep_irq` in bits 4:0.
- R8: Address 0 holds the endpoint select in bits 2:0, and only those bits are written. A write with a select value above 4 is ignored and keeps the previous selection. Addresses 1 to 3 access only the selected endpoint.
- R9: Reserved bits read as 0: select bits 7:3, enable bit 7, configuration bits 5:1, summary bits 7:5, and every bit of addresses 5 to 7.
- R10: After reset every flag, enable and configuration bit is 0, the select is endpoint 0, `ep_irq` is 0 and `irq` is 0.
- R11: Configuration register (address 3) bit 0 is the direction (1 = IN, 0 = OUT). Bits 7:6 are the type (00 control, 01 isochronous, 10 bulk, 11 interrupt). Both fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pulse | input | 40 | Event set pulses; endpoint n uses bits [8n+7:8n], with the flag layout of R1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| ep_irq | output | 5 | Per-endpoint interrupt summary |
| irq | output | 1 | Global interrupt request |

## Verification
The bench looks for the direction masking at both edges of a direction change. A design that only blocked new sets would leave a stale SETUP flag after the endpoint turns IN, or would raise transmit-ready on an OUT endpoint. It drives a hardware set and a firmware clear into the same cycle, where a design with the priority reversed loses the event. It also drives overflow and underflow under the six per-event enables alone, which exposes a design that wires the flow flags to the wrong enable. Forbidden select writes and writes of 1 to flags are then read back through the port, catching a design that lets a bad select through or lets firmware set a flag.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int NUM_EVT = 8;
  localparam int NUM_ENB = 7;
  localparam int DATA_W  = 8;

  // flag bit positions
  localparam int EV_TXRDY   = 0;
  localparam int EV_RXOUT   = 1;
  localparam int EV_RXSETUP = 2;
  localparam int EV_STALL   = 3;
  localparam int EV_NAKIN   = 4;
  localparam int EV_NAKOUT  = 5;
  localparam int EV_OVF     = 6;
  localparam int EV_UNF     = 7;

  localparam int EN_FLOW    = 6;
  localparam int CFG_DIR    = 0;
  localparam int CFG_TYPE_L = 6;

  typedef enum logic [2:0] {
    A_SEL  = 3'd0,
    A_FLAG = 3'd1,
    A_ENB  = 3'd2,
    A_CFG  = 3'd3,
    A_SUM  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] xtype;
    logic       dir_in;
  } ep_cfg_t;
endpackage

// File: rtl/ep_flag_bank.sv
module ep_flag_bank
  import usb_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] ev_set,
  input  logic               wr_flag,
  input  logic               wr_enb,
  input  logic               wr_cfg,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_EVT-1:0] flags_o,
  output logic [NUM_ENB-1:0] enb_o,
  output ep_cfg_t            cfg_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] flag_q, flag_d, allow, clr;
  logic [NUM_ENB-1:0] enb_q;
  ep_cfg_t            cfg_q;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata[7], wdata[5:1]};

  always_comb begin
    allow             = '1;
    allow[EV_TXRDY]   = cfg_q.dir_in;
    allow[EV_RXSETUP] = ~cfg_q.dir_in;
    clr               = wr_flag ? ~wdata : '0;
    flag_d            = allow & (ev_set | (flag_q & ~clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      enb_q  <= '0;
      cfg_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_enb) enb_q <= wdata[NUM_ENB-1:0];
      if (wr_cfg) begin
        cfg_q.dir_in <= wdata[CFG_DIR];
        cfg_q.xtype  <= wdata[CFG_TYPE_L +: 2];
      end
    end
  end

  assign irq_o   = (|(flag_q[EV_NAKOUT:EV_TXRDY] & enb_q[EV_NAKOUT:EV_TXRDY]))
                 | ((flag_q[EV_OVF] | flag_q[EV_UNF]) & enb_q[EN_FLOW]);
  assign flags_o = flag_q;
  assign enb_o   = enb_q;
  assign cfg_o   = cfg_q;

  AST_SETUP_IN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.dir_in |=> !flag_q[EV_RXSETUP]); // R3
  AST_TXRDY_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.dir_in |=> !flag_q[EV_TXRDY]); // R4

  for (genvar b = 0; b < NUM_EVT; b++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_set[b] && allow[b]) |=> flag_q[b]); // R2
    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[b] && !ev_set[b]) |=> !flag_q[b]); // R1
  end
endmodule

// File: rtl/ep_reg_port.sv
module ep_reg_port
  import usb_evt_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int SEL_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [2:0]                addr,
  input  logic [SEL_W-1:0]          sel_wdata,
  input  logic [NUM_EP*NUM_EVT-1:0] flags_all,
  input  logic [NUM_EP*NUM_ENB-1:0] enb_all,
  input  logic [NUM_EP*3-1:0]       cfg_all,
  input  logic [NUM_EP-1:0]         ep_irq,
  output logic [NUM_EP-1:0]         wr_flag,
  output logic [NUM_EP-1:0]         wr_enb,
  output logic [NUM_EP-1:0]         wr_cfg,
  output logic [DATA_W-1:0]         rdata
);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_EP - 1);

  logic [SEL_W-1:0] sel_q;
  logic             sel_ok;
  int               sidx;
  ep_cfg_t          cur_cfg;

  assign sel_ok = (sel_wdata <= SEL_MAX);
  assign sidx   = int'(sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             sel_q <= '0;
    else if (wr && addr == A_SEL && sel_ok) sel_q <= sel_wdata;
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_dec
    assign wr_flag[e] = wr && (addr == A_FLAG) && (sel_q == SEL_W'(e));
    assign wr_enb[e]  = wr && (addr == A_ENB)  && (sel_q == SEL_W'(e));
    assign wr_cfg[e]  = wr && (addr == A_CFG)  && (sel_q == SEL_W'(e));
  end

  always_comb begin
    rdata   = '0;
    cur_cfg = cfg_all[sidx*3 +: 3];
    case (addr)
      A_SEL:  rdata[SEL_W-1:0]   = sel_q;
      A_FLAG: rdata              = flags_all[sidx*NUM_EVT +: NUM_EVT];
      A_ENB:  rdata[NUM_ENB-1:0] = enb_all[sidx*NUM_ENB +: NUM_ENB];
      A_CFG: begin
        rdata[CFG_DIR]         = cur_cfg.dir_in;
        rdata[CFG_TYPE_L +: 2] = cur_cfg.xtype;
      end
      A_SUM:  rdata[NUM_EP-1:0]  = ep_irq;
      default: rdata = '0;
    endcase
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= SEL_MAX); // R8
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_SEL && sel_wdata > SEL_MAX) |=> $stable(sel_q)); // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_flag, wr_enb, wr_cfg})); // R8
endmodule

// File: rtl/usb_ep_irq_hub.sv
module usb_ep_irq_hub
  import usb_evt_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int SEL_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_EP*NUM_EVT-1:0] ev_pulse,
  input  logic                      reg_wr,
  input  logic [2:0]                reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic [NUM_EP-1:0]         ep_irq,
  output logic                      irq
);
  logic [NUM_EP*NUM_EVT-1:0] flags_all;
  logic [NUM_EP*NUM_ENB-1:0] enb_all;
  logic [NUM_EP*3-1:0]       cfg_all;
  logic [NUM_EP-1:0]         wr_flag, wr_enb, wr_cfg;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    ep_cfg_t cfg_e;
    ep_flag_bank i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_set  (ev_pulse[e*NUM_EVT +: NUM_EVT]),
      .wr_flag (wr_flag[e]),
      .wr_enb  (wr_enb[e]),
      .wr_cfg  (wr_cfg[e]),
      .wdata   (reg_wdata),
      .flags_o (flags_all[e*NUM_EVT +: NUM_EVT]),
      .enb_o   (enb_all[e*NUM_ENB +: NUM_ENB]),
      .cfg_o   (cfg_e),
      .irq_o   (ep_irq[e])
    );
    assign cfg_all[e*3 +: 3] = cfg_e;
  end

  ep_reg_port #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) i_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .sel_wdata (reg_wdata[SEL_W-1:0]),
    .flags_all (flags_all),
    .enb_all   (enb_all),
    .cfg_all   (cfg_all),
    .ep_irq    (ep_irq),
    .wr_flag   (wr_flag),
    .wr_enb    (wr_enb),
    .wr_cfg    (wr_cfg),
    .rdata     (reg_rdata)
  );

  assign irq = |ep_irq;

  AST_IDLE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_all == '0) |-> !irq); // R7
endmodule

// File: tb/test_usb_ep_irq_hub.sv
module test_usb_ep_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [39:0] ev_pulse;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [4:0]  ep_irq;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 0;

  always #5 clk = ~clk;

  usb_ep_irq_hub i_usb_ep_irq_hub (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ep_irq(ep_irq), .irq(irq)
  );

  // {ep[3], dir_in[1], enables[8], events[8], exp_flags[8], exp_irq[1]}
  localparam logic [28:0] VEC [12] = '{
    {3'd0, 1'b0, 8'h02, 8'h02, 8'h02, 1'b1},
    {3'd1, 1'b1, 8'h01, 8'h01, 8'h01, 1'b1},
    {3'd2, 1'b0, 8'h01, 8'h01, 8'h00, 1'b0},
    {3'd3, 1'b1, 8'h04, 8'h04, 8'h00, 1'b0},
    {3'd4, 1'b0, 8'h04, 8'h04, 8'h04, 1'b1},
    {3'd0, 1'b0, 8'h40, 8'h80, 8'h80, 1'b1},
    {3'd1, 1'b1, 8'h40, 8'h40, 8'h40, 1'b1},
    {3'd2, 1'b0, 8'h3F, 8'hC0, 8'hC0, 1'b0},
    {3'd3, 1'b0, 8'h08, 8'h08, 8'h08, 1'b1},
    {3'd4, 1'b1, 8'h10, 8'h20, 8'h20, 1'b0},
    {3'd0, 1'b1, 8'h20, 8'h3B, 8'h3B, 1'b1},
    {3'd1, 1'b0, 8'h00, 8'hFF, 8'hFE, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int ep, input logic [7:0] ev);
    ev_pulse[ep*8 +: 8] = ev;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; ev_pulse = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(3'd0, d); chk("R10 select", d, 8'h00);
    rd(3'd1, d); chk("R10 flags", d, 8'h00);
    rd(3'd3, d); chk("R10 config", d, 8'h00);
    chk("R10 ep_irq", {3'b0, ep_irq}, 8'h00);
    chk("R10 irq", {7'b0, irq}, 8'h00);

    // vector table: R1 R3 R4 R5 R6 R7
    for (int v = 0; v < 12; v++) begin
      logic [28:0] t;
      int          ep;
      t  = VEC[v];
      ep = int'(t[28:26]);
      wr(3'd0, {5'b0, t[28:26]});
      wr(3'd3, {7'b0, t[25]});
      wr(3'd2, t[24:17]);
      pulse(ep, t[16:9]);
      rd(3'd1, d); chk($sformatf("R1/R3/R4 flags vec%0d", v), d, t[8:1]);
      chk($sformatf("R5/R6 ep_irq vec%0d", v), {7'b0, ep_irq[ep]}, {7'b0, t[0]});
      chk($sformatf("R7 irq vec%0d", v), {7'b0, irq}, {7'b0, t[0]});
      wr(3'd1, 8'h00);
      rd(3'd1, d); chk($sformatf("R1 cleared vec%0d", v), d, 8'h00);
      chk($sformatf("R7 ep_irq drop vec%0d", v), {3'b0, ep_irq}, 8'h00);
      wr(3'd2, 8'h00);
    end

    // R1: writing 1 keeps, writing 0 clears, never sets
    wr(3'd0, 8'd1); wr(3'd3, 8'h01);
    pulse(1, 8'h09);
    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk("R1 write ones keep", d, 8'h09);
    wr(3'd1, 8'hFE);
    rd(3'd1, d); chk("R1 write zero clears bit0", d, 8'h08);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk("R1 firmware cannot set", d, 8'h00);

    // R2: set and clear in the same cycle
    ev_pulse[1*8 +: 8] = 8'h10;
    wr(3'd1, 8'h00);
    ev_pulse = '0;
    rd(3'd1, d); chk("R2 set wins", d, 8'h10);
    wr(3'd1, 8'h00);

    // R3: SETUP flag drops when endpoint turns IN
    wr(3'd0, 8'd2); wr(3'd3, 8'h00);
    pulse(2, 8'h04);
    rd(3'd1, d); chk("R3 setup on OUT", d, 8'h04);
    wr(3'd3, 8'h01);
    @(negedge clk);
    rd(3'd1, d); chk("R3 setup cleared after IN", d, 8'h00);

    // R8: select steering and forbidden values
    pulse(2, 8'h08);
    wr(3'd0, 8'd3);
    rd(3'd1, d); chk("R8 other endpoint untouched", d, 8'h00);
    wr(3'd0, 8'd5);
    rd(3'd0, d); chk("R8 select 5 ignored", d, 8'h03);
    wr(3'd0, 8'd7);
    rd(3'd0, d); chk("R8 select 7 ignored", d, 8'h03);
    wr(3'd0, 8'd2);
    rd(3'd1, d); chk("R8 steered read", d, 8'h08);
    wr(3'd1, 8'h00);

    // R11 and R9: config encoding and reserved bits
    wr(3'd0, 8'd4);
    wr(3'd3, 8'h81);
    rd(3'd3, d); chk("R11 bulk IN readback", d, 8'h81);
    wr(3'd3, 8'hFF);
    rd(3'd3, d); chk("R9 config reserved", d, 8'hC1);
    wr(3'd2, 8'hFF);
    rd(3'd2, d); chk("R9 enable reserved", d, 8'h7F);
    rd(3'd0, d); chk("R9 select reserved", d, 8'h04);
    rd(3'd5, d); chk("R9 address 5", d, 8'h00);
    rd(3'd7, d); chk("R9 address 7", d, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    // R7: global OR across two endpoints
    wr(3'd0, 8'd0); wr(3'd2, 8'h02);
    wr(3'd0, 8'd3); wr(3'd2, 8'h08);
    pulse(0, 8'h02);
    pulse(3, 8'h08);
    rd(3'd4, d); chk("R7 summary two", d, 8'h09);
    wr(3'd1, 8'h00);
    rd(3'd4, d); chk("R7 summary one", d, 8'h01);
    chk("R7 irq still high", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'd0); wr(3'd1, 8'h00);
    chk("R7 irq low", {7'b0, irq}, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule